// File: doc/BRIEF.md
# Paired-Device Select and Soft-Reset Responder

This block lets two devices hang off one shared register interface. Each device has a strap input that says whether it is unit 0 or unit 1. Both devices see every host register write. Each one records the unit-select bit of the head/select register and compares it with its strap. From that comparison it decides whether its own engine runs a command the host writes. There is one exception: the diagnostics opcode sent to unit 0 starts both devices at once.

The block also tracks the soft-reset and interrupt-mask bits of the device-control byte. It holds the device in reset while soft-reset is set. When the host clears soft-reset, it releases the hold and gives the status logic a one-cycle busy-set pulse.

Finally it forms the inverted unit-address byte from the current head, the write-in-progress flag and the select state. Bit 7 of that byte is never driven, so the port carries only bits 6..0.

Top module: `drive_pair_responder`

## Requirements
- R1: After `rst_n` goes low, `exec_o`, `diag_o`, `srst_hold_o` and `busy_set_o` are 0. The stored unit-select bit is 0 and interrupts are unmasked, so a device strapped as unit 0 shows `drive_en_o`=1 and `irq_en_o`=1, and a device strapped as unit 1 shows both as 0.
- R2: A head/select write stores bit 4 of `wr_data_i` as the unit-select bit. The device is selected when that bit equals `strap_unit_i`. `drive_en_o` is 1 only while the device is selected and not held in soft reset.
- R3: A command write (`wr_cmd_i`) on a selected device that is not held raises `exec_o` for exactly the next cycle, with `opcode_o` equal to the written byte. A device that is not selected gives no `exec_o` pulse.
- R4: Opcode 90h written while the stored unit-select bit is 0 executes on both devices, whatever the strap. Its `exec_o` pulse comes with `diag_o`=1. Opcode 90h with unit-select 1 follows R3.
- R5: A device-control write with bit 2 set raises `srst_hold_o` in the next cycle and keeps it high. While the hold is high, command writes produce no `exec_o` pulse.
- R6: A device-control write with bit 2 clear, made while the hold is high, drops `srst_hold_o` and raises `busy_set_o` in the same cycle. `busy_set_o` lasts exactly one cycle and occurs at no other time.
- R7: Bit 1 of a device-control write is the active-low interrupt enable. `irq_en_o` is 1 only when that stored bit is 0 and the device is selected. The other bits of the device-control byte (7..3 and 0) have no effect on any output.
- R8: `addr_byte_o[6]` is the inverse of `write_busy_i`, and `addr_byte_o[5:2]` is the one's complement of `head_cur_i`, so head 3 reads 1100b.
- R9: `addr_byte_o[0]` is 0 only when the device is strapped unit 0, selected and not held. `addr_byte_o[1]` is 0 only when it is strapped unit 1, selected and not held. Otherwise both bits read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_unit_i | input | 1 | Strap: 0 = unit 0, 1 = unit 1 |
| wr_head_i | input | 1 | One-cycle strobe: host writes the head/select register |
| wr_ctrl_i | input | 1 | One-cycle strobe: host writes the device-control byte |
| wr_cmd_i | input | 1 | One-cycle strobe: host writes the command register |
| wr_data_i | input | 8 | Byte carried by the strobed write |
| head_cur_i | input | 4 | Currently selected head |
| write_busy_i | input | 1 | Media write in progress |
| exec_o | output | 1 | One-cycle start pulse for this device's command engine |
| diag_o | output | 1 | Marks an `exec_o` pulse that started the shared diagnostics |
| opcode_o | output | 8 | Opcode of the last executed command |
| srst_hold_o | output | 1 | Soft-reset hold |
| busy_set_o | output | 1 | One-cycle pulse on soft-reset release |
| drive_en_o | output | 1 | Device may drive the read data bus |
| irq_en_o | output | 1 | Device may drive its interrupt line |
| addr_byte_o | output | 7 | Bits 6..0 of the inverted unit-address byte |

## Verification
If the stored unit-select bit is wrong, `drive_en_o`, `irq_en_o` and `addr_byte_o[1:0]` show it in the cycle after the head/select write. `exec_o` shows it on the next command. If the stored soft-reset bit is wrong, `srst_hold_o` shows it in the cycle after the control write, and the missing or extra `busy_set_o` pulse appears at that same edge. A wrong execute decision shows up only as a missing or extra `exec_o` pulse in the single cycle after the command write. For that reason every command is checked in that exact cycle and again one cycle later.

// File: rtl/drive_pair_pkg.sv
package drive_pair_pkg;
    localparam int DATA_W   = 8;
    localparam int HEAD_W   = 4;
    localparam int DRV_BIT  = 4;
    localparam int SRST_BIT = 2;
    localparam int NIEN_BIT = 1;
    localparam logic [DATA_W-1:0] DIAG_OPC = 8'h90;

    typedef struct packed {
        logic drv;
        logic nien;
        logic srst;
        logic busy_set;
    } ctl_state_t;
endpackage

// File: rtl/drive_pair_regs.sv
module drive_pair_regs
    import drive_pair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_head_i,
    input  logic wr_ctrl_i,
    input  logic head_drv_i,
    input  logic ctrl_srst_i,
    input  logic ctrl_nien_i,
    output logic drv_o,
    output logic nien_o,
    output logic srst_o,
    output logic busy_set_o
);
    ctl_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.busy_set = 1'b0;
        if (wr_head_i) begin
            s_d.drv = head_drv_i;
        end
        if (wr_ctrl_i) begin
            s_d.nien     = ctrl_nien_i;
            s_d.srst     = ctrl_srst_i;
            s_d.busy_set = s_q.srst && !ctrl_srst_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign drv_o      = s_q.drv;
    assign nien_o     = s_q.nien;
    assign srst_o     = s_q.srst;
    assign busy_set_o = s_q.busy_set;

    AST_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_o) |-> busy_set_o); // R6
    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_set_o |=> !busy_set_o); // R6
    AST_BUSY_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_set_o |-> $past(srst_o) && !srst_o); // R6
endmodule

// File: rtl/drive_pair_exec.sv
module drive_pair_exec
    import drive_pair_pkg::*;
#(
    parameter int W = DATA_W,
    parameter logic [W-1:0] DIAG = DIAG_OPC
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cmd_i,
    input  logic [W-1:0] data_i,
    input  logic         drv_i,
    input  logic         strap_i,
    input  logic         srst_i,
    output logic         exec_o,
    output logic         diag_o,
    output logic [W-1:0] opcode_o
);
    typedef struct packed {
        logic         exec;
        logic         diag;
        logic [W-1:0] opcode;
    } exe_state_t;

    exe_state_t s_d, s_q;
    logic sel, is_diag, run;

    always_comb begin
        sel     = (drv_i == strap_i);
        is_diag = (data_i == DIAG);
        run     = wr_cmd_i && !srst_i && (sel || (is_diag && !drv_i));
        s_d      = s_q;
        s_d.exec = run;
        s_d.diag = run && is_diag;
        if (run) begin
            s_d.opcode = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign exec_o   = s_q.exec;
    assign diag_o   = s_q.diag;
    assign opcode_o = s_q.opcode;

    AST_EXEC_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> $past(wr_cmd_i)); // R3
    AST_NO_EXEC_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> !$past(srst_i)); // R5
    AST_DIAG_WITH_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        diag_o |-> exec_o && (opcode_o == DIAG)); // R4
endmodule

// File: rtl/drive_pair_addr.sv
module drive_pair_addr #(
    parameter int HW = 4
)(
    input  logic [HW-1:0] head_i,
    input  logic          wbusy_i,
    input  logic          sel_i,
    input  logic          strap_i,
    input  logic          srst_i,
    output logic [HW+2:0] addr_o
);
    logic live;

    always_comb begin
        live   = sel_i && !srst_i;
        addr_o = {!wbusy_i, ~head_i, !(live && strap_i), !(live && !strap_i)};
    end
endmodule

// File: rtl/drive_pair_responder.sv
module drive_pair_responder
    import drive_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_unit_i,
    input  logic              wr_head_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_cmd_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [HEAD_W-1:0] head_cur_i,
    input  logic              write_busy_i,
    output logic              exec_o,
    output logic              diag_o,
    output logic [DATA_W-1:0] opcode_o,
    output logic              srst_hold_o,
    output logic              busy_set_o,
    output logic              drive_en_o,
    output logic              irq_en_o,
    output logic [HEAD_W+2:0] addr_byte_o
);
    logic drv_q, nien_q, srst_q, sel;

    drive_pair_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_head_i  (wr_head_i),
        .wr_ctrl_i  (wr_ctrl_i),
        .head_drv_i (wr_data_i[DRV_BIT]),
        .ctrl_srst_i(wr_data_i[SRST_BIT]),
        .ctrl_nien_i(wr_data_i[NIEN_BIT]),
        .drv_o      (drv_q),
        .nien_o     (nien_q),
        .srst_o     (srst_q),
        .busy_set_o (busy_set_o)
    );

    drive_pair_exec #(.W(DATA_W), .DIAG(DIAG_OPC)) exec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cmd_i(wr_cmd_i),
        .data_i  (wr_data_i),
        .drv_i   (drv_q),
        .strap_i (strap_unit_i),
        .srst_i  (srst_q),
        .exec_o  (exec_o),
        .diag_o  (diag_o),
        .opcode_o(opcode_o)
    );

    assign sel         = (drv_q == strap_unit_i);
    assign srst_hold_o = srst_q;
    assign drive_en_o  = sel && !srst_q;
    assign irq_en_o    = sel && !nien_q;

    drive_pair_addr #(.HW(HEAD_W)) addr_i (
        .head_i (head_cur_i),
        .wbusy_i(write_busy_i),
        .sel_i  (sel),
        .strap_i(strap_unit_i),
        .srst_i (srst_q),
        .addr_o (addr_byte_o)
    );

    AST_DS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~addr_byte_o[1:0])); // R9
    AST_DS_MATCHES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_byte_o[1:0] != 2'b11) |-> drive_en_o); // R9
    AST_HOLD_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_hold_o |-> !drive_en_o); // R2
endmodule

// File: tb/drive_pair_responder_tb_top.sv
`timescale 1ns/1ps
module drive_pair_responder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0, wr_head = 1'b0, wr_ctrl = 1'b0, wr_cmd = 1'b0, wbusy = 1'b0;
    logic [7:0] wdata = '0;
    logic [3:0] head = '0;
    logic exec, diag, hold, bset, den, ien;
    logic [7:0] opc;
    logic [6:0] abyte;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic m_drv = 0, m_nien = 0, m_srst = 0;
    logic [7:0] m_opc = '0;

    always #2.5 clk = ~clk;

    drive_pair_responder dut_i (
        .clk(clk), .rst_n(rst_n), .strap_unit_i(strap), .wr_head_i(wr_head),
        .wr_ctrl_i(wr_ctrl), .wr_cmd_i(wr_cmd), .wr_data_i(wdata),
        .head_cur_i(head), .write_busy_i(wbusy), .exec_o(exec), .diag_o(diag),
        .opcode_o(opc), .srst_hold_o(hold), .busy_set_o(bset),
        .drive_en_o(den), .irq_en_o(ien), .addr_byte_o(abyte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic m_sel();
        return m_drv == strap;
    endfunction

    function automatic logic [6:0] exp_addr();
        logic live = m_sel() && !m_srst;
        return {!wbusy, ~head, !(live && strap), !(live && !strap)};
    endfunction

    function automatic logic exp_run(input logic [7:0] op);
        return !m_srst && (m_sel() || (op == 8'h90 && !m_drv));
    endfunction

    task automatic check_static();
        check("R2 drive_en", den, m_sel() && !m_srst);
        check("R7 irq_en", ien, m_sel() && !m_nien);
        check("R5 hold", hold, m_srst);
        check("R8/R9 addr", abyte, exp_addr());
    endtask

    // kind: 0 head, 1 ctrl, 2 cmd, 3 idle
    task automatic step(input int kind, input logic [7:0] d);
        logic run, isd, rel;
        run = (kind == 2) && exp_run(d);
        isd = run && (d == 8'h90);
        rel = (kind == 1) && m_srst && !d[2];
        wdata = d;
        wr_head = (kind == 0);
        wr_ctrl = (kind == 1);
        wr_cmd  = (kind == 2);
        @(posedge clk);
        @(negedge clk);
        wr_head = 0; wr_ctrl = 0; wr_cmd = 0;
        if (kind == 0) m_drv = d[4];
        if (kind == 1) begin m_srst = d[2]; m_nien = d[1]; end
        if (run) m_opc = d;
        head = 4'($urandom_range(0, 15));
        wbusy = 1'($urandom_range(0, 1));
        #0.1;
        check("R3 exec", exec, run);
        check("R4 diag", diag, isd);
        check("R6 busy_set", bset, rel);
        if (run) check("R3 opcode", opc, m_opc);
        check_static();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0416));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state with strap 0
        check("R1 exec", exec, 0);
        check("R1 diag", diag, 0);
        check("R1 hold", hold, 0);
        check("R1 busy", bset, 0);
        check("R1 drive_en", den, 1);
        check("R1 irq_en", ien, 1);
        strap = 1; #0.1;
        check("R1 drive_en strap1", den, 0);
        check("R1 irq_en strap1", ien, 0);
        rst_n = 1;
        @(negedge clk);
        // R8: head 3 gives 1100b
        head = 4'd3; wbusy = 1; #0.1;
        check("R8 head3", abyte[5:2], 4'b1100);
        check("R8 wbusy", abyte[6], 0);
        // R4: diag, unit-select 0, strap 1 -> executes
        step(2, 8'h90);
        step(3, 8'h00);
        check("R3 single pulse", exec, 0);
        // R3: non-diag, not selected
        step(2, 8'h20);
        // R4: diag with unit-select 1 on strap 0 -> no execute
        strap = 0;
        step(0, 8'hB0);
        step(2, 8'h90);
        strap = 1;
        step(2, 8'h90);
        // R7: stray bits 7..3 and 0 have no effect
        step(1, 8'hF9);
        step(1, 8'h02);
        // R5/R6: hold, command ignored, release
        step(1, 8'h04);
        step(2, 8'hC8);
        step(1, 8'h08);
        step(3, 8'h00);
        check("R6 busy one cycle", bset, 0);
        // random phase
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [7:0] d;
            if (i % 150 == 0) strap = ~strap;
            k = $urandom_range(0, 3);
            d = 8'($urandom);
            if ($urandom_range(0, 3) == 0) d = 8'h90;
            step(k, d);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule